// File: doc/BRIEF.md
# Emergency Output High-Impedance Controller

This block protects a motor-drive stage by forcing selected timer outputs into a high-impedance state as soon as a fault appears. It watches four active-low fault lines. A falling edge on a line sets a sticky flag for it. The flags are combined with a comparison-fault input from the output-level comparator, with per-group enables and with software force bits. The result is a set of active-high per-pin tri-state overrides, which go to the pad logic of the chip.

The overrides fall into two groups.

- Six high-current outputs, arranged as three complementary pairs. Each pair has its own zone enable.
- Four general timer-channel outputs, with one enable per pin. These answer only to the fourth fault line and to their own software force bit.

An override reaches a pad only if that pad's function select is general I/O or timer output. Software reads and clears the flags through a small register port. A flag is cleared by writing 0 to it after it has been read as 1.

Top module: `hiz_guard`

## Requirements
- R1: Synchronous reset clears all flags, control bits and channel enables. While reset is held and afterwards, until a new cause appears, every override output is 0, and register reads return 0.
- R2: A high-to-low transition on fault line i sets flag bit i of the flag register. The flag register is at address 2, with bit 0 = line A, bit 1 = line B, bit 2 = line C, bit 3 = line D. The affected overrides rise on the third rising clock edge after the input changes, and not earlier. A rising transition or a steady level sets nothing. A flag, once set, stays set until it is cleared.
- R3: The control register is at address 0, with bits [2:0] = pair enables, bit 3 = compare enable, bit 4 = pair software force, bit 5 = channel software force, bit 6 = line D enable. Pair k drives override bits 2k and 2k+1. It is forced when its pair enable is set and any of these holds: flag A, flag B, flag C, (comparison fault AND compare enable), or pair software force. Override writes take effect on the same edge as the register write.
- R4: The channel enables are at address 1, bits [3:0]. Channel pin j is forced when its enable is set and either (flag D AND line D enable) or the channel software force is set. Flag D never forces a pair.
- R5: Pin function codes are 2 bits per pin: 2'b00 = general I/O, 2'b01 = timer, 2'b1x = other. Pin p uses bits [2p+1:2p]. Pair pins are 0..5 and channel pins are 6..9. A pin whose code is other is never forced.
- R6: Writing 0 to a flag bit clears it only if that bit was read as 1 by an earlier read of the flag register. Writing 0 to a bit that has not been read as 1 leaves it set. Writing 1 has no effect.
- R7: If a new falling edge on a line and a valid clear of the same flag fall in the same cycle, the flag stays set.
- R8: When the optional line C is configured out, flag C reads 0 and line C never forces any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_n | input | 4 | Active-low fault lines A, B, C, D (bits 0..3) |
| cmp_fault | input | 1 | Flag from the output-level comparator |
| pin_sel | input | 20 | Function code, 2 bits per pin, pins 0..9 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data, registered one cycle after the read strobe |
| hiz_pair | output | 6 | Tri-state overrides for the three complementary pairs |
| hiz_ch0 | output | 4 | Tri-state overrides for the channel pins |

## Verification
The bench times a fault edge against the output, so a design with one register too many or too few in the synchronizer and edge path is caught as a shifted rise. It writes 0 to a flag that has never been read, and it lines a clear up on the very edge where a new fault edge lands. A design that skips the read-before-clear rule, or that lets the clear win, loses a fault. Pins with a non-timer function, pairs with the zone enable off, and line D with its own enable off must all stay low even while their fault sources are active. A second instance built without line C must ignore that line entirely.

// File: rtl/hiz_pkg.sv
package hiz_pkg;
  localparam int N_FLT = 4;
  localparam int FLT_A = 0;
  localparam int FLT_B = 1;
  localparam int FLT_C = 2;
  localparam int FLT_D = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CH0  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef enum logic [1:0] {
    FN_GPIO    = 2'b00,
    FN_TIMER   = 2'b01,
    FN_OTHER_A = 2'b10,
    FN_OTHER_B = 2'b11
  } pin_fn_e;

  // only pads driven as general I/O or timer output accept the override
  function automatic logic fn_overridable(input logic [1:0] code);
    return (code == FN_GPIO) || (code == FN_TIMER);
  endfunction
endpackage

// File: rtl/hiz_fault_capture.sv
module hiz_fault_capture
  import hiz_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_SRC_C   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_FLT-1:0] fault_n,
  input  logic [N_FLT-1:0] clr_mask,
  output logic [N_FLT-1:0] flags_q,
  output logic [N_FLT-1:0] flags_d,
  output logic [N_FLT-1:0] edge_seen
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < N_FLT; i++) begin : g_src
    if (i == FLT_C && !HAS_SRC_C) begin : g_absent
      assign flags_q[i]   = 1'b0;
      assign flags_d[i]   = 1'b0;
      assign edge_seen[i] = 1'b0;
    end else begin : g_present
      logic [SYNC_STAGES-1:0] sync_r;
      logic                   prev_r;
      logic                   flag_r;
      logic                   fall;
      logic                   nxt;

      assign fall = prev_r & ~sync_r[LAST];
      // a fresh edge beats a clear in the same cycle
      assign nxt  = (flag_r & ~clr_mask[i]) | fall;

      always_ff @(posedge clk) begin
        if (rst) begin
          sync_r <= '1;
          prev_r <= 1'b1;
          flag_r <= 1'b0;
        end else begin
          sync_r <= {sync_r[LAST-1:0], fault_n[i]};
          prev_r <= sync_r[LAST];
          flag_r <= nxt;
        end
      end

      assign flags_q[i]   = flag_r;
      assign flags_d[i]   = nxt;
      assign edge_seen[i] = fall;
    end
  end
endmodule

// File: rtl/hiz_regs.sv
module hiz_regs
  import hiz_pkg::*;
#(
  parameter int N_PAIRS = 3,
  parameter int N_CH0   = 4,
  localparam int CTRL_W = N_PAIRS + 4,
  localparam int REG_W  = (CTRL_W > N_CH0) ? CTRL_W : N_CH0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [N_FLT-1:0]  flags_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_d,
  output logic [N_CH0-1:0]  ch0_q,
  output logic [N_CH0-1:0]  ch0_d,
  output logic [N_FLT-1:0]  clr_mask,
  output logic [N_FLT-1:0]  armed_q,
  output logic [REG_W-1:0]  bus_rdata
);
  logic             wr_ctrl, wr_ch0, wr_flag, rd_flag;
  logic [N_FLT-1:0] armed_d;
  logic [REG_W-1:0] rd_mux;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_ch0  = bus_wr && (bus_addr == ADDR_CH0);
  assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
  assign rd_flag = bus_rd && (bus_addr == ADDR_FLAG);

  assign ctrl_d   = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
  assign ch0_d    = wr_ch0  ? bus_wdata[N_CH0-1:0]  : ch0_q;
  // a zero clears only a bit that software has already seen set
  assign clr_mask = wr_flag ? (~bus_wdata[N_FLT-1:0] & armed_q) : '0;
  assign armed_d  = (armed_q & ~clr_mask) | (rd_flag ? flags_q : '0);

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: rd_mux = REG_W'(ctrl_q);
      ADDR_CH0:  rd_mux = REG_W'(ch0_q);
      ADDR_FLAG: rd_mux = REG_W'(flags_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ch0_q     <= '0;
      armed_q   <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ch0_q   <= ch0_d;
      armed_q <= armed_d;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/hiz_gate.sv
module hiz_gate
  import hiz_pkg::*;
#(
  parameter int N_PAIRS = 3,
  parameter int N_CH0   = 4,
  localparam int CTRL_W = N_PAIRS + 4,
  localparam int N_PINS = 2 * N_PAIRS + N_CH0
) (
  input  logic [N_FLT-1:0]     flags,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic [N_CH0-1:0]     ch0_en,
  input  logic                 cmp_fault,
  input  logic [2*N_PINS-1:0]  pin_sel,
  output logic [2*N_PAIRS-1:0] pair_hiz,
  output logic [N_CH0-1:0]     ch0_hiz
);
  localparam int CB_CMP = N_PAIRS;
  localparam int CB_SWP = N_PAIRS + 1;
  localparam int CB_SWC = N_PAIRS + 2;
  localparam int CB_DEN = N_PAIRS + 3;

  logic pair_cause, ch0_cause;

  assign pair_cause = flags[FLT_A] | flags[FLT_B] | flags[FLT_C]
                    | (cmp_fault & ctrl[CB_CMP]) | ctrl[CB_SWP];
  assign ch0_cause  = (flags[FLT_D] & ctrl[CB_DEN]) | ctrl[CB_SWC];

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int P = 2 * k + s;
      assign pair_hiz[P] = ctrl[k] & pair_cause & fn_overridable(pin_sel[2*P +: 2]);
    end
  end

  for (genvar j = 0; j < N_CH0; j++) begin : g_ch0
    localparam int P = 2 * N_PAIRS + j;
    assign ch0_hiz[j] = ch0_en[j] & ch0_cause & fn_overridable(pin_sel[2*P +: 2]);
  end
endmodule

// File: rtl/hiz_guard.sv
module hiz_guard
  import hiz_pkg::*;
#(
  parameter int N_PAIRS     = 3,
  parameter int N_CH0       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_SRC_C   = 1'b1,
  localparam int CTRL_W = N_PAIRS + 4,
  localparam int REG_W  = (CTRL_W > N_CH0) ? CTRL_W : N_CH0,
  localparam int N_PINS = 2 * N_PAIRS + N_CH0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_FLT-1:0]     fault_n,
  input  logic                 cmp_fault,
  input  logic [2*N_PINS-1:0]  pin_sel,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [2*N_PAIRS-1:0] hiz_pair,
  output logic [N_CH0-1:0]     hiz_ch0
);
  logic [N_FLT-1:0]     flags_q, flags_d, edge_seen, clr_mask, armed_q;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [N_CH0-1:0]     ch0_q, ch0_d;
  logic [2*N_PAIRS-1:0] pair_hiz_c;
  logic [N_CH0-1:0]     ch0_hiz_c;

  hiz_fault_capture #(.SYNC_STAGES(SYNC_STAGES), .HAS_SRC_C(HAS_SRC_C)) u_cap (
    .clk(clk), .rst(rst), .fault_n(fault_n), .clr_mask(clr_mask),
    .flags_q(flags_q), .flags_d(flags_d), .edge_seen(edge_seen)
  );

  hiz_regs #(.N_PAIRS(N_PAIRS), .N_CH0(N_CH0)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flags_q(flags_q), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .ch0_q(ch0_q), .ch0_d(ch0_d), .clr_mask(clr_mask), .armed_q(armed_q),
    .bus_rdata(bus_rdata)
  );

  // the gate sees next-state values so the output flop lands with the flag
  hiz_gate #(.N_PAIRS(N_PAIRS), .N_CH0(N_CH0)) u_gate (
    .flags(flags_d), .ctrl(ctrl_d), .ch0_en(ch0_d), .cmp_fault(cmp_fault),
    .pin_sel(pin_sel), .pair_hiz(pair_hiz_c), .ch0_hiz(ch0_hiz_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hiz_pair <= '0;
      hiz_ch0  <= '0;
    end else begin
      hiz_pair <= pair_hiz_c;
      hiz_ch0  <= ch0_hiz_c;
    end
  end
endmodule

// File: rtl/hiz_guard_chk.sv
module hiz_guard_chk
  import hiz_pkg::*;
#(
  parameter int N_PAIRS = 3,
  parameter int N_CH0   = 4,
  localparam int CTRL_W = N_PAIRS + 4,
  localparam int N_PINS = 2 * N_PAIRS + N_CH0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [1:0]           bus_addr,
  input logic [2*N_PINS-1:0]  pin_sel,
  input logic [2*N_PAIRS-1:0] hiz_pair,
  input logic [N_CH0-1:0]     hiz_ch0,
  input logic [N_FLT-1:0]     flags,
  input logic [N_FLT-1:0]     armed,
  input logic [N_FLT-1:0]     edge_seen,
  input logic [CTRL_W-1:0]    ctrl,
  input logic [N_CH0-1:0]     ch0_en
);
  logic [N_PINS-1:0]    bad_pin;
  logic [N_PINS-1:0]    hiz_all;
  logic [2*N_PAIRS-1:0] pair_mask;

  always_comb begin
    for (int p = 0; p < N_PINS; p++) bad_pin[p] = !fn_overridable(pin_sel[2*p +: 2]);
    for (int k = 0; k < N_PAIRS; k++) begin
      pair_mask[2*k]   = ctrl[k];
      pair_mask[2*k+1] = ctrl[k];
    end
  end
  assign hiz_all = {hiz_ch0, hiz_pair};

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (hiz_pair == '0 && hiz_ch0 == '0 && flags == '0));

  // R2
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_FLAG) |=> ((flags & $past(flags)) == $past(flags)));

  // R7
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_seen != '0) |=> ((flags & $past(edge_seen)) == $past(edge_seen)));

  // R6
  armed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags) & ~flags & ~$past(armed)) == '0));

  // R3
  pair_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((hiz_pair & ~pair_mask) == '0));

  // R4
  ch0_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((hiz_ch0 & ~ch0_en) == '0));

  // R5
  pin_func_chk: assert property (@(posedge clk) disable iff (rst)
    (bad_pin != '0) |=> ((hiz_all & $past(bad_pin)) == '0));
endmodule

bind hiz_guard hiz_guard_chk #(.N_PAIRS(N_PAIRS), .N_CH0(N_CH0)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .pin_sel(pin_sel),
  .hiz_pair(hiz_pair), .hiz_ch0(hiz_ch0), .flags(flags_q), .armed(armed_q),
  .edge_seen(edge_seen), .ctrl(ctrl_q), .ch0_en(ch0_q)
);

// File: tb/tb_hiz_guard.sv
module tb_hiz_guard;
  localparam int REG_W = 7;
  localparam logic [1:0] A_CTRL = 2'd0, A_CH0 = 2'd1, A_FLAG = 2'd2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       fault_n = 4'hF;
  logic             cmp_fault = 1'b0;
  logic [19:0]      pin_sel = '0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]       bus_addr = '0;
  logic [REG_W-1:0] bus_wdata = '0;
  logic [REG_W-1:0] rdata, rdata_nc;
  logic [5:0]       hiz_pair, hiz_pair_nc;
  logic [3:0]       hiz_ch0, hiz_ch0_nc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [REG_W-1:0] rd_v, rd_nc;

  always #5 clk = ~clk;

  hiz_guard dut (
    .clk(clk), .rst(rst), .fault_n(fault_n), .cmp_fault(cmp_fault), .pin_sel(pin_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .hiz_pair(hiz_pair), .hiz_ch0(hiz_ch0)
  );

  hiz_guard #(.HAS_SRC_C(1'b0)) dut_noc (
    .clk(clk), .rst(rst), .fault_n(fault_n), .cmp_fault(cmp_fault), .pin_sel(pin_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_nc), .hiz_pair(hiz_pair_nc), .hiz_ch0(hiz_ch0_nc)
  );

  // {ctrl[6:0], ch0_en[3:0], cmp_fault, exp_pair[5:0], exp_ch0[3:0]}, flags all clear
  localparam logic [21:0] VEC [8] = '{
    {7'h00, 4'h0, 1'b0, 6'h00, 4'h0},
    {7'h17, 4'h0, 1'b0, 6'h3F, 4'h0},
    {7'h15, 4'h0, 1'b0, 6'h33, 4'h0},
    {7'h0B, 4'h0, 1'b1, 6'h0F, 4'h0},
    {7'h03, 4'h0, 1'b1, 6'h00, 4'h0},
    {7'h20, 4'hA, 1'b0, 6'h00, 4'hA},
    {7'h27, 4'hF, 1'b1, 6'h00, 4'hF},
    {7'h40, 4'hF, 1'b0, 6'h00, 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [REG_W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    rd_v = rdata; rd_nc = rdata_nc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("R1 reset hiz_pair", hiz_pair, 0);
    chk("R1 reset hiz_ch0", hiz_ch0, 0);
    rst = 1'b0;
    tick(1);
    bus_read(A_CTRL); chk("R1 reset ctrl", rd_v, 0);
    bus_read(A_CH0);  chk("R1 reset ch0 enables", rd_v, 0);
    bus_read(A_FLAG); chk("R1 reset flags", rd_v, 0);

    // R3 R4 gating table
    for (int i = 0; i < 8; i++) begin
      cmp_fault = VEC[i][10];
      bus_write(A_CTRL, VEC[i][21:15]);
      bus_write(A_CH0, {3'b0, VEC[i][14:11]});
      chk($sformatf("R3 table %0d pairs", i), hiz_pair, VEC[i][9:4]);
      chk($sformatf("R4 table %0d ch0", i), hiz_ch0, VEC[i][3:0]);
    end
    cmp_fault = 1'b0;
    bus_write(A_CH0, 0);

    // R8 optional line C
    bus_write(A_CTRL, 7'h07);
    fault_n[2] = 1'b0;
    tick(4);
    chk("R2 line C forces pairs", hiz_pair, 6'h3F);
    chk("R8 no-C instance pairs", hiz_pair_nc, 6'h00);
    bus_read(A_FLAG);
    chk("R2 flag C set", rd_v, 7'h04);
    chk("R8 no-C flag reads 0", rd_nc, 7'h00);
    bus_write(A_FLAG, 0);
    chk("R6 armed clear drops pairs", hiz_pair, 6'h00);
    fault_n[2] = 1'b1;
    tick(4);

    // R2 latency on line A
    fault_n[0] = 1'b0;
    tick(2);
    chk("R2 no rise after 2 edges", hiz_pair, 6'h00);
    tick(1);
    chk("R2 rise on 3rd edge", hiz_pair, 6'h3F);
    bus_write(A_FLAG, 0);
    bus_read(A_FLAG);
    chk("R6 unread flag survives zero write", rd_v, 7'h01);
    bus_write(A_FLAG, 0);
    bus_read(A_FLAG);
    chk("R6 read-then-zero clears", rd_v, 7'h00);
    bus_write(A_FLAG, 7'h7F);
    bus_read(A_FLAG);
    chk("R6 writing ones sets nothing", rd_v, 7'h00);
    fault_n[0] = 1'b1;
    tick(5);
    bus_read(A_FLAG);
    chk("R2 rising edge sets nothing", rd_v, 7'h00);
    chk("R2 pairs quiet after rising edge", hiz_pair, 6'h00);

    // R7 set beats clear on line B
    fault_n[1] = 1'b0;
    tick(4);
    bus_read(A_FLAG);
    chk("R2 flag B set", rd_v, 7'h02);
    fault_n[1] = 1'b1;
    tick(4);
    fault_n[1] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_write(A_FLAG, 0);
    bus_read(A_FLAG);
    chk("R7 new edge beats clear", rd_v, 7'h02);
    bus_write(A_FLAG, 0);
    bus_read(A_FLAG);
    chk("R7 later clear works", rd_v, 7'h00);
    fault_n[1] = 1'b1;

    // R4 line D with and without its enable
    bus_write(A_CTRL, 7'h00);
    bus_write(A_CH0, 7'h03);
    fault_n[3] = 1'b0;
    tick(4);
    chk("R4 D flag without enable", hiz_ch0, 4'h0);
    bus_write(A_CTRL, 7'h47);
    chk("R4 D flag with enable", hiz_ch0, 4'h3);
    chk("R4 D never forces pairs", hiz_pair, 6'h00);

    // R5 pin function qualification
    pin_sel = '0;
    pin_sel[1:0]   = 2'b10;
    pin_sel[5:4]   = 2'b01;
    pin_sel[15:14] = 2'b11;
    bus_write(A_CTRL, 7'h37);
    bus_write(A_CH0, 7'h0F);
    chk("R5 pair pins filtered", hiz_pair, 6'h3E);
    chk("R5 ch0 pins filtered", hiz_ch0, 4'hD);
    bus_read(A_CTRL);
    chk("R3 ctrl readback", rd_v, 7'h37);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule